// File: doc/BRIEF.md
# USB Host Frame Timer

This block keeps the frame timing of a USB host controller. A down-counter of the bit times left in the current frame runs on a one-cycle bit-time enable. When it has reached zero, the next bit-time tick reloads it from a frame length that software programs. Software also programs a toggle bit next to that length. The toggle is copied into the remaining-count register at each reload, so software can tell whether a new length has taken effect yet. A 16-bit frame number advances at every frame boundary. A boundary is either such a reload or the entry into the operational state.

After each boundary the block publishes the new frame number to memory that the host and the controller share, in a fixed order. It first waits for the start-of-frame packet to be reported as sent. It then raises a request that carries the frame number and holds it until the memory agent acknowledges. Only after that acknowledge does it allow descriptor fetching for the frame and set the start-of-frame status flag. Software clears the flag by writing a 1 to it. Generating the SOF packet, mastering the bus and processing descriptors are done elsewhere.

Top module: `usb_frame_timer`

## Requirements
- R1: After synchronous reset, every read value (interval, remaining, frame number, status) is 0, and `frame_pulse`, `mem_req` and `fetch_ok` are 0.
- R2: A cycle with `ivl_wr`=1 stores `ivl_wval` and `ivl_wtog`. From the next cycle `ivl_rd` reads with the length in bits 13:0, the toggle in bit 31 and every other bit 0.
- R3: While operational (`oper_i` high in this cycle and the previous one), a `bit_tick` with a nonzero remaining count lowers the count (`rem_rd` bits 13:0) by one on the next cycle. Without a tick, the count holds.
- R4: While operational, a `bit_tick` with a remaining count of 0 does four things on the next cycle: it reloads the count from the stored length, copies the stored toggle into `rem_rd` bit 31, adds one to the frame number (`fnum_rd` bits 15:0), and raises `frame_pulse` for that cycle. A length written in the same cycle as the reload takes effect only at the following reload.
- R5: The first cycle with `oper_i` high after a cycle with it low is an entry. On the next cycle, the count holds the stored length, the frame number has advanced by one and `frame_pulse` is high. `rem_rd` bit 31 is unchanged, and any `bit_tick` in the entry cycle is ignored.
- R6: In a cycle with `oper_i` low, the count, the remaining toggle and the frame number do not change, `frame_pulse` is low on the next cycle, and no new `mem_req` is raised.
- R7: From the cycle in which `frame_pulse` is high until the frame number has been acknowledged, `fetch_ok` is low. `mem_req` rises only on the cycle after a `sof_sent` that is seen in the pulse cycle or later, and `mem_data` then equals `fnum_rd` bits 15:0.
- R8: While `mem_req` is high and `mem_ack` is low, `mem_req` stays high and `mem_data` stays stable. On the cycle after `mem_ack` is seen, `mem_req` is low, the status flag (`sts_rd` bit 2) is set, and `fetch_ok` is high unless another boundary has occurred since the request.
- R9: A cycle with `sts_wr`=1 and `sts_wbit`=1 clears `sts_rd` bit 2, and `sts_wbit`=0 leaves it unchanged. An acknowledge in the same cycle as a clear leaves the flag set.
- R10: The frame number wraps from FFFFh to 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oper_i | input | 1 | High while the controller is in the operational state |
| bit_tick | input | 1 | One-cycle enable per USB bit time |
| ivl_wr | input | 1 | Write strobe for the frame interval register |
| ivl_wtog | input | 1 | Interval toggle bit to write |
| ivl_wval | input | 14 | Frame length in bit times to write |
| sof_sent | input | 1 | Start-of-frame packet has gone out |
| mem_ack | input | 1 | Memory agent has stored `mem_data` |
| sts_wr | input | 1 | Write strobe for the status flag |
| sts_wbit | input | 1 | Value written to the flag bit (1 clears) |
| ivl_rd | output | 32 | Interval register read value |
| rem_rd | output | 32 | Remaining-count register read value |
| fnum_rd | output | 32 | Frame number register read value |
| sts_rd | output | 32 | Status read value, flag in bit 2 |
| frame_pulse | output | 1 | One-cycle pulse at each frame boundary |
| mem_req | output | 1 | Request to store the frame number |
| mem_data | output | 16 | Frame number to store |
| fetch_ok | output | 1 | Descriptor fetching allowed for this frame |

## Verification
The assertions check the following on every cycle: the count steps down by one per tick, a tick at zero produces a boundary pulse, counters freeze outside the operational state, `fetch_ok` is low in the pulse cycle, the request holds with stable data until it is acknowledged, and a clear writes the flag to zero. Other behaviour shows only in the bench's scenarios. This covers the exact reload value and the toggle copy, the order from boundary through SOF to request, the priority of set over clear, and the wrap of the frame number after 65,536 boundaries. The bench also checks that a new length takes effect only at the following reload, through a reference model compared on every cycle under random ticks, writes and acknowledges.

// File: rtl/uft_pkg.sv
package uft_pkg;
  localparam int REG_W   = 32;
  localparam int TOG_BIT = 31;
  localparam int SF_BIT  = 2;

  typedef enum logic [1:0] {
    PS_IDLE     = 2'd0,
    PS_WAIT_SOF = 2'd1,
    PS_REQ      = 2'd2
  } pub_state_t;
endpackage

// File: rtl/uft_interval_reg.sv
module uft_interval_reg #(
  parameter int REM_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             wtog,
  input  logic [REM_W-1:0] wval,
  output logic [REM_W-1:0] ivl_val,
  output logic             ivl_tog
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ivl_val <= '0;
      ivl_tog <= 1'b0;
    end else if (wr) begin
      ivl_val <= wval;
      ivl_tog <= wtog;
    end
  end
endmodule

// File: rtl/uft_frame_counter.sv
module uft_frame_counter #(
  parameter int REM_W = 14,
  parameter int FN_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             oper,
  input  logic             bit_tick,
  input  logic [REM_W-1:0] ivl_val,
  input  logic             ivl_tog,
  output logic [REM_W-1:0] rem,
  output logic             rem_tog,
  output logic [FN_W-1:0]  fnum,
  output logic             bnd,
  output logic             pulse
);
  localparam logic [REM_W-1:0] REM_ONE = {{(REM_W-1){1'b0}}, 1'b1};
  localparam logic [FN_W-1:0]  FN_ONE  = {{(FN_W-1){1'b0}}, 1'b1};

  logic oper_q;
  logic entry;
  logic run_tick;
  logic reload;

  always_comb begin
    entry    = oper && !oper_q;
    run_tick = oper && oper_q && bit_tick;
    reload   = run_tick && (rem == '0);
    bnd      = entry || reload;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oper_q  <= 1'b0;
      rem     <= '0;
      rem_tog <= 1'b0;
      fnum    <= '0;
      pulse   <= 1'b0;
    end else begin
      oper_q <= oper;
      pulse  <= bnd;
      if (entry) begin
        rem  <= ivl_val;
        fnum <= fnum + FN_ONE;
      end else if (reload) begin
        rem     <= ivl_val;
        rem_tog <= ivl_tog;
        fnum    <= fnum + FN_ONE;
      end else if (run_tick) begin
        rem <= rem - REM_ONE;
      end
    end
  end
endmodule

// File: rtl/uft_publish_seq.sv
module uft_publish_seq
  import uft_pkg::*;
#(
  parameter int FN_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            oper,
  input  logic            bnd,
  input  logic [FN_W-1:0] fnum,
  input  logic            sof_sent,
  input  logic            mem_ack,
  output logic            mem_req,
  output logic [FN_W-1:0] mem_data,
  output logic            fetch_ok,
  output logic            sof_set
);
  pub_state_t st;
  logic       pend;

  assign sof_set = (st == PS_REQ) && mem_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= PS_IDLE;
      pend     <= 1'b0;
      mem_req  <= 1'b0;
      mem_data <= '0;
      fetch_ok <= 1'b0;
    end else begin
      case (st)
        PS_IDLE: begin
          if (bnd) begin
            st       <= PS_WAIT_SOF;
            fetch_ok <= 1'b0;
          end
        end
        PS_WAIT_SOF: begin
          if (bnd) begin
            fetch_ok <= 1'b0;
          end else if (!oper) begin
            st <= PS_IDLE;
          end else if (sof_sent) begin
            st       <= PS_REQ;
            mem_req  <= 1'b1;
            mem_data <= fnum;
          end
        end
        PS_REQ: begin
          if (mem_ack) begin
            mem_req  <= 1'b0;
            pend     <= 1'b0;
            fetch_ok <= !(pend || bnd);
            st       <= (pend || bnd) ? PS_WAIT_SOF : PS_IDLE;
          end else if (bnd) begin
            pend <= 1'b1;
          end
        end
        default: st <= PS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uft_status_flag.sv
module uft_status_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr_wr,
  input  logic clr_bit,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)                    flag <= 1'b0;
    else if (set)               flag <= 1'b1;
    else if (clr_wr && clr_bit) flag <= 1'b0;
  end
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
  import uft_pkg::*;
#(
  parameter int REM_W = 14,
  parameter int FN_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               oper_i,
  input  logic               bit_tick,
  input  logic               ivl_wr,
  input  logic               ivl_wtog,
  input  logic [REM_W-1:0]   ivl_wval,
  input  logic               sof_sent,
  input  logic               mem_ack,
  input  logic               sts_wr,
  input  logic               sts_wbit,
  output logic [REG_W-1:0]   ivl_rd,
  output logic [REG_W-1:0]   rem_rd,
  output logic [REG_W-1:0]   fnum_rd,
  output logic [REG_W-1:0]   sts_rd,
  output logic               frame_pulse,
  output logic               mem_req,
  output logic [FN_W-1:0]    mem_data,
  output logic               fetch_ok
);
  logic [REM_W-1:0] ivl_val;
  logic             ivl_tog;
  logic [REM_W-1:0] rem;
  logic             rem_tog;
  logic [FN_W-1:0]  fnum;
  logic             bnd;
  logic             sof_set;
  logic             sf_flag;

  uft_interval_reg #(.REM_W(REM_W)) u_ivl (
    .clk(clk), .rst(rst), .wr(ivl_wr), .wtog(ivl_wtog), .wval(ivl_wval),
    .ivl_val(ivl_val), .ivl_tog(ivl_tog)
  );

  uft_frame_counter #(.REM_W(REM_W), .FN_W(FN_W)) u_cnt (
    .clk(clk), .rst(rst), .oper(oper_i), .bit_tick(bit_tick),
    .ivl_val(ivl_val), .ivl_tog(ivl_tog),
    .rem(rem), .rem_tog(rem_tog), .fnum(fnum), .bnd(bnd), .pulse(frame_pulse)
  );

  uft_publish_seq #(.FN_W(FN_W)) u_pub (
    .clk(clk), .rst(rst), .oper(oper_i), .bnd(bnd), .fnum(fnum),
    .sof_sent(sof_sent), .mem_ack(mem_ack),
    .mem_req(mem_req), .mem_data(mem_data), .fetch_ok(fetch_ok), .sof_set(sof_set)
  );

  uft_status_flag u_sts (
    .clk(clk), .rst(rst), .set(sof_set), .clr_wr(sts_wr), .clr_bit(sts_wbit),
    .flag(sf_flag)
  );

  always_comb begin
    ivl_rd                 = '0;
    ivl_rd[REM_W-1:0]      = ivl_val;
    ivl_rd[TOG_BIT]        = ivl_tog;
    rem_rd                 = '0;
    rem_rd[REM_W-1:0]      = rem;
    rem_rd[TOG_BIT]        = rem_tog;
    fnum_rd                = '0;
    fnum_rd[FN_W-1:0]      = fnum;
    sts_rd                 = '0;
    sts_rd[SF_BIT]         = sf_flag;
  end
endmodule

// File: rtl/uft_checker.sv
module uft_checker #(
  parameter int REM_W = 14,
  parameter int FN_W  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             oper_i,
  input logic             bit_tick,
  input logic [REM_W-1:0] rem,
  input logic [FN_W-1:0]  fnum,
  input logic             frame_pulse,
  input logic             mem_req,
  input logic             mem_ack,
  input logic [FN_W-1:0]  mem_data,
  input logic             fetch_ok,
  input logic             sf_flag,
  input logic             sts_wr,
  input logic             sts_wbit
);
  logic op_prev;
  always_ff @(posedge clk) begin
    if (rst) op_prev <= 1'b0;
    else     op_prev <= oper_i;
  end

  a_r3_step_down: assert property (@(posedge clk) disable iff (rst)
    (oper_i && op_prev && bit_tick && rem != '0)
      |=> rem == REM_W'($past(rem) - REM_W'(1)));

  a_r4_zero_pulses: assert property (@(posedge clk) disable iff (rst)
    (oper_i && op_prev && bit_tick && rem == '0) |=> frame_pulse);

  a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
    !oper_i |=> ($stable(fnum) && !frame_pulse));

  a_r7_no_fetch: assert property (@(posedge clk) disable iff (rst)
    frame_pulse |-> !fetch_ok);

  a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_data)));

  a_r8_ack_done: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> (!mem_req && sf_flag));

  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    (sts_wr && sts_wbit && !(mem_req && mem_ack)) |=> !sf_flag);
endmodule

bind usb_frame_timer uft_checker #(.REM_W(REM_W), .FN_W(FN_W)) u_chk (
  .clk(clk), .rst(rst), .oper_i(oper_i), .bit_tick(bit_tick),
  .rem(rem_rd[REM_W-1:0]), .fnum(fnum_rd[FN_W-1:0]),
  .frame_pulse(frame_pulse), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_data(mem_data), .fetch_ok(fetch_ok), .sf_flag(sts_rd[2]),
  .sts_wr(sts_wr), .sts_wbit(sts_wbit)
);

// File: tb/usb_frame_timer_bench.sv
module usb_frame_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        oper_i = 0, bit_tick = 0, ivl_wr = 0, ivl_wtog = 0;
  logic [13:0] ivl_wval = '0;
  logic        sof_sent = 0, mem_ack = 0, sts_wr = 0, sts_wbit = 0;
  logic [31:0] ivl_rd, rem_rd, fnum_rd, sts_rd;
  logic        frame_pulse, mem_req, fetch_ok;
  logic [15:0] mem_data;

  int checks = 0, errors = 0, cycles = 0;
  bit auto_ack = 1'b1;

  always #10 clk = ~clk;

  usb_frame_timer u_usb_frame_timer (.*);

  // Reference model, updated from the requirements at each rising edge
  logic        m_oq, m_tog, m_itog, m_pulse, m_req, m_fetch, m_flag, m_pend;
  logic [13:0] m_rem, m_ivl;
  logic [15:0] m_fn, m_data;
  logic [1:0]  m_st;  // 0 idle, 1 wait sof, 2 request
  logic        e_ent, e_rel, e_bnd, e_run;

  always @(posedge clk) begin
    if (rst) begin
      m_oq = 0; m_tog = 0; m_itog = 0; m_pulse = 0; m_req = 0; m_fetch = 0;
      m_flag = 0; m_pend = 0; m_rem = 0; m_ivl = 0; m_fn = 0; m_data = 0; m_st = 0;
    end else begin
      e_ent = oper_i && !m_oq;
      e_run = oper_i && m_oq && bit_tick;
      e_rel = e_run && (m_rem == 0);
      e_bnd = e_ent || e_rel;
      // status flag uses the acknowledge seen in the request state
      if (m_st == 2 && mem_ack) m_flag = 1;
      else if (sts_wr && sts_wbit) m_flag = 0;
      case (m_st)
        0: if (e_bnd) begin m_st = 1; m_fetch = 0; end
        1: if (e_bnd) m_fetch = 0;
           else if (!oper_i) m_st = 0;
           else if (sof_sent) begin m_st = 2; m_req = 1; m_data = m_fn; end
        default: if (mem_ack) begin
             m_req = 0; m_fetch = !(m_pend || e_bnd);
             m_st = (m_pend || e_bnd) ? 2'd1 : 2'd0; m_pend = 0;
           end else if (e_bnd) m_pend = 1;
      endcase
      if (e_ent) begin m_rem = m_ivl; m_fn = m_fn + 1; end
      else if (e_rel) begin m_rem = m_ivl; m_tog = m_itog; m_fn = m_fn + 1; end
      else if (e_run) m_rem = m_rem - 1;
      m_pulse = e_bnd;
      m_oq = oper_i;
      if (ivl_wr) begin m_ivl = ivl_wval; m_itog = ivl_wtog; end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("R2 interval read", ivl_rd, {m_itog, 17'd0, m_ivl});
    chk("R3 R4 remaining read", rem_rd, {m_tog, 17'd0, m_rem});
    chk("R4 R5 frame number", fnum_rd, {16'd0, m_fn});
    chk("R4 R5 frame pulse", {31'd0, frame_pulse}, {31'd0, m_pulse});
    chk("R8 request", {31'd0, mem_req}, {31'd0, m_req});
    if (m_req) chk("R8 request data", {16'd0, mem_data}, {16'd0, m_data});
    chk("R7 fetch allowed", {31'd0, fetch_ok}, {31'd0, m_fetch});
    chk("R9 status read", sts_rd, {29'd0, m_flag, 2'd0});
  endtask

  // one cycle: wait for the falling edge, compare, clear single-cycle strobes
  task automatic cyc();
    @(negedge clk);
    cycles++;
    if (!rst) cmp_all();
    ivl_wr = 0; sof_sent = 0; sts_wr = 0;
    mem_ack = auto_ack && mem_req && ($urandom % 3 == 0);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 190000) begin
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    logic [15:0] fn0;
    logic [31:0] rem0;
    bit wrapped;
    bit seen;
    void'($urandom(32'd1562));
    repeat (3) cyc();
    rst = 0;
    cyc();
    // R1 reset state
    chk("R1 reset interval", ivl_rd, 0);
    chk("R1 reset remaining", rem_rd, 0);
    chk("R1 reset frame number", fnum_rd, 0);
    chk("R1 reset status", sts_rd, 0);
    chk("R1 reset outputs", {29'd0, frame_pulse, mem_req, fetch_ok}, 0);

    // R2 interval write, R5 entry into operational state
    ivl_wr = 1; ivl_wtog = 1; ivl_wval = 14'd5;
    cyc();
    chk("R2 interval fields", ivl_rd, 32'h8000_0005);
    oper_i = 1; bit_tick = 1;
    cyc();
    chk("R5 entry reload", rem_rd, 32'h0000_0005);
    chk("R5 entry increment", fnum_rd, 32'd1);
    chk("R5 entry pulse", {31'd0, frame_pulse}, 1);
    bit_tick = 0;

    // R6 counters frozen outside the operational state
    repeat (3) cyc();
    oper_i = 0; bit_tick = 1;
    cyc();
    fn0 = fnum_rd[15:0]; rem0 = rem_rd; seen = 0;
    for (int i = 0; i < 10; i++) begin
      sof_sent = 1;
      cyc();
      if (frame_pulse || mem_req) seen = 1;
    end
    chk("R6 frame number held", fnum_rd, {16'd0, fn0});
    chk("R6 remaining held", rem_rd, rem0);
    chk("R6 no pulse or request", {31'd0, seen}, 0);

    // R7 R8 R9 publish order and flag priority
    auto_ack = 0;
    sts_wr = 1; sts_wbit = 1;
    ivl_wr = 1; ivl_wtog = 0; ivl_wval = 14'd3;
    cyc();
    oper_i = 1; bit_tick = 0;
    cyc();  // entry boundary
    chk("R7 fetch low at boundary", {31'd0, fetch_ok}, 0);
    repeat (3) cyc();
    chk("R7 no request before sof", {31'd0, mem_req}, 0);
    sof_sent = 1;
    cyc();
    chk("R7 request after sof", {31'd0, mem_req}, 1);
    chk("R7 request carries frame number", {16'd0, mem_data}, {16'd0, fnum_rd[15:0]});
    repeat (3) cyc();
    chk("R8 request held", {31'd0, mem_req}, 1);
    chk("R9 flag clear before ack", {31'd0, sts_rd[2]}, 0);
    mem_ack = 1; sts_wr = 1; sts_wbit = 1;
    cyc();
    chk("R9 set wins over clear", {31'd0, sts_rd[2]}, 1);
    chk("R8 fetch after ack", {30'd0, fetch_ok, mem_req}, 32'd2);
    sts_wr = 1; sts_wbit = 0;
    cyc();
    chk("R9 write of 0 ignored", {31'd0, sts_rd[2]}, 1);
    sts_wr = 1; sts_wbit = 1;
    cyc();
    chk("R9 write of 1 clears", {31'd0, sts_rd[2]}, 0);

    // R4 new length only at the following reload
    bit_tick = 1;
    while (rem_rd[13:0] != 0) cyc();
    ivl_wr = 1; ivl_wtog = 1; ivl_wval = 14'd9;
    cyc();
    chk("R4 reload uses previous length", rem_rd, 32'h0000_0003);
    while (rem_rd[13:0] != 0) cyc();
    cyc();
    chk("R4 reload copies toggle and new length", rem_rd, 32'h8000_0009);

    // R10 wrap of the frame number with a zero length
    auto_ack = 1;
    ivl_wr = 1; ivl_wtog = 0; ivl_wval = 14'd0;
    cyc();
    wrapped = 0;
    for (int i = 0; i < 65540; i++) begin
      fn0 = fnum_rd[15:0];
      cyc();
      if (fn0 == 16'hFFFF && fnum_rd[15:0] == 16'h0000) wrapped = 1;
    end
    chk("R10 frame number wrapped", {31'd0, wrapped}, 1);

    // random mix against the model
    for (int i = 0; i < 20000; i++) begin
      cyc();
      bit_tick = ($urandom % 2) == 0;
      if ($urandom % 200 == 0) oper_i = ~oper_i;
      if ($urandom % 50 == 0) begin
        ivl_wr = 1; ivl_wtog = $urandom % 2; ivl_wval = 14'($urandom % 24);
      end
      sof_sent = ($urandom % 6) == 0;
      if ($urandom % 20 == 0) begin sts_wr = 1; sts_wbit = $urandom % 2; end
    end
    cyc();
    finish_run();
  end
endmodule